// File: doc/BRIEF.md
# Two-Input Converter Serial Control Slave

This block is the two-wire serial (I2C) slave front end of a small two-input, 10-bit analog-to-digital converter. It oversamples SCL and SDA with a fast system clock and finds START and STOP conditions. It matches the 7-bit device address, which is a parameter. It then either takes in command bytes from the master or returns conversion results to it. SDA is open-drain: the block only ever pulls the line low, through an output-enable pin.

A written byte goes to one of two control registers, chosen by its top bit. The configuration register sets the scan mode, the channel select and the single-ended or differential mode. The setup register holds the clock-mode bit. From these registers the block drives the analog input selection: which pin is the positive input, and which pin or ground is the negative input.

On a read, the block takes a snapshot of the result port when it acknowledges the address. It returns the snapshot as two bytes, with leading ones as padding. While the master keeps acknowledging, the block sends the same two bytes again. A not-acknowledge from the master makes the block let go of the bus.

Top module: `adc_i2c_slave`

## Requirements
- R1: After reset: scanSel = 00, chanSel = 0, singleEnded = 1, extClock = 0, muxPos = 0, muxNeg = 0 (ground), and sdaOe = 0.
- R2: The block acknowledges an address byte whose upper 7 bits equal SLAVE_ADDR, for both write (bit 0 = 0) and read (bit 0 = 1), by pulling SDA low during the ninth clock. It pulls SDA only in acknowledge slots and for 0 data bits of a read.
- R3: When the address does not match, the block gives no acknowledge. It then ignores the bus until the next START: later bytes get no acknowledge, change no register and are never driven.
- R4: A written byte with bit 7 = 0 updates the configuration register: scanSel takes bits 6:5, chanSel takes bit 1 and singleEnded takes bit 0. Bits 4:2 are ignored. Register outputs change only while SCL is low.
- R5: A written byte with bit 7 = 1 sets extClock from bit 3 and leaves the configuration outputs unchanged. All its other bits are ignored.
- R6: Every data byte written after a matching write address is acknowledged. Several bytes can be written in one transfer, and each one is routed by its own bit 7.
- R7: A read returns two bytes, MSB first. The first byte is six 1 bits followed by result bits 9:8. The second byte is result bits 7:0.
- R8: The result is sampled when the read address is acknowledged. Changes on convResult after that point do not affect the bytes sent in that transfer.
- R9: When the master acknowledges a byte, reading continues. The same two-byte pair is sent again and again for as long as the master keeps acknowledging.
- R10: After a not-acknowledge from the master, sdaOe stays 0 on every later SCL clock until a STOP or START.
- R11: muxPos is 0 for AIN0 and 1 for AIN1. muxNeg is 0 for ground, 1 for AIN0 and 2 for AIN1. In single-ended mode the negative input is ground and the positive input is the selected channel. In differential mode, channel select 0 gives AIN0+/AIN1- and channel select 1 gives AIN1+/AIN0-.
- R12: sdaOe changes only while SCL is low. The line is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| convResult | input | 10 | Latest conversion result from the converter |
| scanSel | output | 2 | Scan-mode selection |
| chanSel | output | 1 | Channel select |
| singleEnded | output | 1 | 1 = single-ended, 0 = differential |
| extClock | output | 1 | Clock mode: 0 = internal, 1 = external |
| muxPos | output | 1 | Positive input: 0 = AIN0, 1 = AIN1 |
| muxNeg | output | 2 | Negative input: 0 = ground, 1 = AIN0, 2 = AIN1 |

## Verification
The state hardest to reach from the ports is the one in which the sampled result must stay put. This happens during a long read in which the master keeps acknowledging while convResult keeps changing. The stimulus drives a new random value onto convResult just after each read-address acknowledge. It then reads a random number of byte pairs and checks every pair against the value sampled at the acknowledge. The released bus after a master not-acknowledge is reached by clocking extra dummy bits after the NACK and checking that each one reads back as 1.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ADDR     = 3'd1,
    ST_ADDR_ACK = 3'd2,
    ST_RX       = 3'd3,
    ST_RX_ACK   = 3'd4,
    ST_TX       = 3'd5,
    ST_MACK     = 3'd6,
    ST_IGNORE   = 3'd7
  } busState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // take one SDA bit into the receive byte
    logic loadTx;    // snapshot the result into the transmit register
    logic shiftTx;   // advance the transmit register by one bit
    logic writeReg;  // commit the received byte to a control register
  } dpStrobe_t;

  localparam logic [1:0] NEG_GND  = 2'd0;
  localparam logic [1:0] NEG_AIN0 = 2'd1;
  localparam logic [1:0] NEG_AIN1 = 2'd2;

  function automatic logic [1:0] negFor(input logic sgl, input logic chan);
    if (sgl) return NEG_GND;
    return chan ? NEG_AIN0 : NEG_AIN1;
  endfunction

endpackage

// File: rtl/adc_i2c_dpath.sv
module adc_i2c_dpath
  import adc_i2c_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RES_W       = 10,
  parameter int CLK_BIT     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  input  logic [RES_W-1:0]  resIn,
  input  dpStrobe_t         strobe,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaS,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit,
  output logic [1:0]        scanSel,
  output logic              chanSel,
  output logic              singleEnded,
  output logic              extClock,
  output logic              muxPos,
  output logic [1:0]        muxNeg
);

  localparam int TX_W  = 2 * DATA_W;
  localparam int PAD_W = TX_W - RES_W;
  localparam int SEL_B = DATA_W - 1;

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic                   sclD;
  logic                   sdaD;
  logic                   sclS;
  logic [TX_W-1:0]        txReg;

  // Input synchronisers, idle-high reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], scl};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclSync[SYNC_STAGES-1];
      sdaD    <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  // Receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxByte <= '0;
    else if (strobe.shiftIn) rxByte <= {rxByte[DATA_W-2:0], sdaS};
  end

  // Transmit register: padded snapshot, rotating so the pair repeats
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txReg <= '1;
    else if (strobe.loadTx) txReg <= {{PAD_W{1'b1}}, resIn};
    else if (strobe.shiftTx) txReg <= {txReg[TX_W-2:0], txReg[TX_W-1]};
  end

  assign txBit = txReg[TX_W-1];

  // Control registers, routed by the top bit of the byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanSel     <= 2'b00;
      chanSel     <= 1'b0;
      singleEnded <= 1'b1;
      extClock    <= 1'b0;
    end else if (strobe.writeReg) begin
      if (rxByte[SEL_B]) begin
        extClock <= rxByte[CLK_BIT];
      end else begin
        scanSel     <= rxByte[6:5];
        chanSel     <= rxByte[1];
        singleEnded <= rxByte[0];
      end
    end
  end

  assign muxPos = chanSel;
  assign muxNeg = negFor(singleEnded, chanSel);

endmodule

// File: rtl/adc_i2c_ctrl.sv
module adc_i2c_ctrl
  import adc_i2c_pkg::*;
#(
  parameter int                ADDR_W     = 7,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaS,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         strobe,
  output logic              sdaOe,
  output busState_t         busState
);

  localparam int                CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  BYTE_END = CNT_W'(DATA_W);

  logic [CNT_W-1:0] bitCnt;
  logic             masterAck;
  logic             addrHit;
  logic             isRead;
  logic             byteDone;

  assign addrHit  = (rxByte[DATA_W-1 -: ADDR_W] == SLAVE_ADDR);
  assign isRead   = rxByte[0];
  assign byteDone = (bitCnt == BYTE_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busState  <= ST_IDLE;
      bitCnt    <= '0;
      masterAck <= 1'b0;
    end else if (startDet) begin
      busState <= ST_ADDR;
      bitCnt   <= '0;
    end else if (stopDet) begin
      busState <= ST_IDLE;
    end else begin
      unique case (busState)
        ST_ADDR, ST_RX, ST_TX: begin
          if (sclRise && !byteDone) bitCnt <= bitCnt + 1'b1;
          if (sclFall && byteDone) begin
            if (busState == ST_RX)      busState <= ST_RX_ACK;
            else if (busState == ST_TX) busState <= ST_MACK;
            else                        busState <= addrHit ? ST_ADDR_ACK : ST_IGNORE;
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            busState <= isRead ? ST_TX : ST_RX;
            bitCnt   <= '0;
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            busState <= ST_RX;
            bitCnt   <= '0;
          end
        end
        ST_MACK: begin
          if (sclRise) masterAck <= ~sdaS;
          if (sclFall) begin
            busState <= masterAck ? ST_TX : ST_IGNORE;
            bitCnt   <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.shiftIn  = sclRise && !byteDone && (busState == ST_ADDR || busState == ST_RX);
    strobe.writeReg = sclFall && byteDone && (busState == ST_RX);
    strobe.loadTx   = sclFall && isRead && (busState == ST_ADDR_ACK);
    strobe.shiftTx  = sclFall && (bitCnt != '0) && (busState == ST_TX);
  end

  always_comb begin
    unique case (busState)
      ST_ADDR_ACK, ST_RX_ACK: sdaOe = 1'b1;
      ST_TX:                  sdaOe = ~txBit;
      default:                sdaOe = 1'b0;
    endcase
  end

endmodule

// File: rtl/adc_i2c_slave.sv
module adc_i2c_slave
  import adc_i2c_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter int                DATA_W      = 8,
  parameter int                RES_W       = 10,
  parameter int                CLK_BIT     = 3,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h36
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scl,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic [RES_W-1:0] convResult,
  output logic [1:0]       scanSel,
  output logic             chanSel,
  output logic             singleEnded,
  output logic             extClock,
  output logic             muxPos,
  output logic [1:0]       muxNeg
);

  dpStrobe_t         strobe;
  busState_t         busState;
  logic              sclRise;
  logic              sclFall;
  logic              startDet;
  logic              stopDet;
  logic              sdaS;
  logic              txBit;
  logic [DATA_W-1:0] rxByte;

  adc_i2c_dpath #(
    .DATA_W(DATA_W), .RES_W(RES_W), .CLK_BIT(CLK_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .resIn(convResult),
    .strobe(strobe), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .rxByte(rxByte),
    .txBit(txBit), .scanSel(scanSel), .chanSel(chanSel),
    .singleEnded(singleEnded), .extClock(extClock),
    .muxPos(muxPos), .muxNeg(muxNeg)
  );

  adc_i2c_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLAVE_ADDR(SLAVE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .rxByte(rxByte),
    .txBit(txBit), .strobe(strobe), .sdaOe(sdaOe), .busState(busState)
  );

endmodule

// File: rtl/adc_i2c_slave_chk.sv
module adc_i2c_slave_chk
  import adc_i2c_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       scl,
  input logic       sdaOe,
  input logic [1:0] scanSel,
  input logic       chanSel,
  input logic       singleEnded,
  input logic       extClock,
  input logic       muxPos,
  input logic [1:0] muxNeg,
  input logic [2:0] busState
);

  assert_oe_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (busState == ST_ADDR_ACK || busState == ST_RX_ACK || busState == ST_TX));

  assert_released_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IGNORE) |-> !sdaOe);

  assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !scl);

  assert_cfg_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({scanSel, chanSel, singleEnded}) |-> !scl);

  assert_clk_scl_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(extClock) |-> !scl);

  assert_mux_se_R11: assert property (@(posedge clk) disable iff (!rstN)
    singleEnded |-> (muxNeg == NEG_GND));

  assert_mux_diff_R11: assert property (@(posedge clk) disable iff (!rstN)
    !singleEnded |-> (muxNeg != NEG_GND) && ((muxNeg == NEG_AIN0) == muxPos));

endmodule

bind adc_i2c_slave adc_i2c_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaOe(sdaOe), .scanSel(scanSel),
  .chanSel(chanSel), .singleEnded(singleEnded), .extClock(extClock),
  .muxPos(muxPos), .muxNeg(muxNeg), .busState(busState)
);

// File: tb/adc_i2c_slave_tb.sv
module adc_i2c_slave_tb;

  localparam logic [6:0] ADDR = 7'h36;
  localparam int Q = 10;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaBus;
  logic       sdaOe;
  logic [9:0] convResult = '0;
  logic [1:0] scanSel;
  logic       chanSel, singleEnded, extClock, muxPos;
  logic [1:0] muxNeg;

  int  nChecks = 0;
  int  nFails = 0;
  int  oeViol = 0;
  bit  finished = 0;

  logic [1:0] eScan = 2'b00;
  logic       eChan = 1'b0;
  logic       eSgl = 1'b1;
  logic       eExt = 1'b0;

  assign sdaBus = sdaM & ~sdaOe;

  always #5 clk = ~clk;

  adc_i2c_slave u_dut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .convResult(convResult), .scanSel(scanSel), .chanSel(chanSel),
    .singleEnded(singleEnded), .extClock(extClock), .muxPos(muxPos),
    .muxNeg(muxNeg)
  );

  // R12 monitor: output enable may only move while SCL is low
  logic oePrev = 1'b0;
  always @(negedge clk) begin
    if (rstN && (sdaOe != oePrev) && scl) oeViol++;
    oePrev <= sdaOe;
  end

  function automatic logic [7:0] expHi(input logic [9:0] r);
    return {6'b111111, r[9:8]};
  endfunction

  function automatic logic [1:0] expNeg(input logic sgl, input logic chan);
    if (sgl) return 2'd0;
    return chan ? 2'd1 : 2'd2;
  endfunction

  task automatic chkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q); scl = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q); scl = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(Q); scl = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(Q);
  endtask

  task automatic writeBit(input logic b);
    sdaM = b; waitClk(Q); scl = 1'b1; waitClk(H); scl = 1'b0; waitClk(Q);
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; waitClk(Q); scl = 1'b1; waitClk(H / 2);
    b = sdaBus; waitClk(H / 2); scl = 1'b0; waitClk(Q);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    ack = ~b;
  endtask

  task automatic readByte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) readBit(v[i]);
    writeBit(nack);
  endtask

  task automatic modelByte(input logic [7:0] v);
    if (v[7]) eExt = v[3];
    else begin
      eScan = v[6:5]; eChan = v[1]; eSgl = v[0];
    end
  endtask

  task automatic checkRegs(input string req);
    chkEq({req, " scanSel"}, scanSel, eScan);
    chkEq({req, " chanSel"}, chanSel, eChan);
    chkEq({req, " singleEnded"}, singleEnded, eSgl);
    chkEq({req, " extClock"}, extClock, eExt);
    chkEq("R11 muxPos", muxPos, eChan);
    chkEq("R11 muxNeg", muxNeg, expNeg(eSgl, eChan));
  endtask

  task automatic writeTxn(input logic [7:0] bytes [], input logic repStart);
    logic ack;
    if (repStart) begin
      sdaM = 1'b1; waitClk(Q); scl = 1'b1; waitClk(Q);
      sdaM = 1'b0; waitClk(Q); scl = 1'b0; waitClk(Q);
    end else busStart();
    writeByte({ADDR, 1'b0}, ack);
    chkEq("R2 write address ack", ack, 1);
    foreach (bytes[i]) begin
      writeByte(bytes[i], ack);
      chkEq("R6 data byte ack", ack, 1);
      modelByte(bytes[i]);
    end
  endtask

  task automatic readTxn(input logic [9:0] res, input int pairs, input logic noStop);
    logic ack;
    logic [7:0] hi, lo;
    logic b;
    convResult = res;
    busStart();
    writeByte({ADDR, 1'b1}, ack);
    chkEq("R2 read address ack", ack, 1);
    convResult = ~res;  // R8: later changes must not leak
    for (int p = 0; p < pairs; p++) begin
      readByte(hi, 1'b0);
      readByte(lo, (p == pairs - 1));
      chkEq("R7 first byte (R8 R9)", hi, expHi(res));
      chkEq("R7 second byte (R8 R9)", lo, res[7:0]);
    end
    // R10: bus released after NACK
    for (int k = 0; k < 3; k++) begin
      readBit(b);
      chkEq("R10 released after NACK", b, 1);
    end
    if (!noStop) busStop();
  endtask

  task automatic badAddrTxn(input logic rd);
    logic ack, b;
    logic [6:0] a;
    a = 7'($urandom_range(0, 127));
    if (a == ADDR) a = a ^ 7'h01;
    busStart();
    writeByte({a, rd}, ack);
    chkEq("R3 mismatched address nack", ack, 0);
    if (rd) begin
      for (int k = 0; k < 8; k++) begin
        readBit(b);
        chkEq("R3 ignored read not driven", b, 1);
      end
    end else begin
      writeByte(8'h00, ack);
      chkEq("R3 ignored byte nack", ack, 0);
      writeByte(8'hFF, ack);
      chkEq("R3 ignored byte nack", ack, 0);
    end
    busStop();
    checkRegs("R3 regs unchanged");
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] bl [];
    void'($urandom(32'h1C0FFEE));
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R1 reset state
    chkEq("R1 scanSel", scanSel, 0);
    chkEq("R1 chanSel", chanSel, 0);
    chkEq("R1 singleEnded", singleEnded, 1);
    chkEq("R1 extClock", extClock, 0);
    chkEq("R1 sdaOe", sdaOe, 0);
    chkEq("R1 muxPos", muxPos, 0);
    chkEq("R1 muxNeg", muxNeg, 0);

    // R4: config write with don't-care bits set
    bl = new[1]; bl[0] = 8'h5E;
    writeTxn(bl, 1'b0); busStop();
    checkRegs("R4 config");

    // R5: setup write, config untouched
    bl = new[1]; bl[0] = 8'hF8;
    writeTxn(bl, 1'b0); busStop();
    checkRegs("R5 setup");

    // R6: several bytes in one transfer, then repeated START into a read
    bl = new[3]; bl[0] = 8'h21; bl[1] = 8'h80; bl[2] = 8'h03;
    writeTxn(bl, 1'b0);
    checkRegs("R6 multi-byte");
    readTxn(10'h2A5, 2, 1'b0);

    // R3 mismatched address, write and read
    badAddrTxn(1'b0);
    badAddrTxn(1'b1);

    // R7 corners
    readTxn(10'h000, 1, 1'b0);
    readTxn(10'h3FF, 1, 1'b0);
    // R9 long repeat
    readTxn(10'h155, 4, 1'b0);

    // Random mix
    for (int it = 0; it < 24; it++) begin
      int kind;
      kind = $urandom_range(0, 3);
      if (kind == 0) begin
        readTxn(10'($urandom_range(0, 1023)), $urandom_range(1, 3), 1'b0);
      end else if (kind == 3) begin
        badAddrTxn(1'($urandom_range(0, 1)));
      end else begin
        bl = new[$urandom_range(1, 3)];
        foreach (bl[i]) bl[i] = 8'($urandom_range(0, 255));
        writeTxn(bl, 1'b0); busStop();
        checkRegs("R4 R5 random write");
      end
    end

    chkEq("R12 sdaOe moved while SCL high", oeViol, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule